// File: doc/BRIEF.md
# Teletext Composite Sync and Display Window Generator

This block produces the composite text sync for a 625-line television raster, together with a strobe that marks the active text display area, from a free-running timebase tick at three ticks per microsecond. Each 64 µs line is 192 ticks long. A field is counted in half-lines, so the field blanking is built as a plain sequence: five equalizing half-lines, then five broad half-lines, then five more equalizing half-lines. Every half-line after that is an ordinary one, and it carries a line sync pulse only when it begins a line.

A two-bit mode input selects the field length. The choices are interlaced fields of 312.5 lines each, non-interlaced fields of 312 and 313 lines in turn, or non-interlaced fields of 312 lines each. When a newsflash or subtitle page is shown, the override input forces interlaced operation. The field parity is brought out on an ODD/EVEN output, which drives the vertical deflection. Software can force this output low, either directly or automatically while a TV picture is on screen. The current tick, line and field are also brought out so that the pixel path can address its character memory.

Top module: `tt_sync_gen`

## Requirements
- R1: After reset the outputs are tick_pos 0, line_no 1, field_id 0, odd_even 0, disp_active 0 and csync_n 0, because the first half-line of the first field is an equalizing one.
- R2: tick_pos advances by one on each cycle with tick_en high, wraps from 191 to 0, and holds when tick_en is low; ticks 0..95 form the first half-line of a line and ticks 96..191 the second.
- R3: Outside field blanking, csync_n is low for ticks 0..13 of every line, and it stays high throughout the second half of the line.
- R4: Half-lines 0..4 and 10..14 of a field are equalizing: csync_n is low for the first 7 ticks of each such half-line.
- R5: Half-lines 5..9 of a field are broad: csync_n is low for the first 82 ticks of each such half-line.
- R6: mode_sel 2'b00 (interlaced) and 2'b11 (scan-locked, handled as interlaced) give 625 half-lines per field. mode_sel 2'b01 gives 624 half-lines in fields with field_id 0 and 626 in fields with field_id 1. mode_sel 2'b10 gives 624 half-lines in every field.
- R7: While flash_sub is 1, the field lengths are those of mode 2'b00, whatever mode_sel holds.
- R8: line_no is 1 for the first line of a field that starts at tick 0. It is 0 for the half-line that opens a field starting at tick 96. It increments each time tick_pos returns to 0.
- R9: disp_active is high only when line_no is 42..291 and tick_pos is 50..169.
- R10: field_id starts at 0 and toggles at each field start; odd_even equals field_id when neither forcing condition holds.
- R11: odd_even is 0 whenever oe_disable is 1.
- R12: odd_even is 0 whenever oe_auto and picture_on are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timebase tick, one per third of a microsecond |
| mode_sel | input | 2 | Field-length mode: 00 interlaced, 01 312/313, 10 312/312, 11 scan-locked |
| flash_sub | input | 1 | Newsflash or subtitle page shown; forces interlaced |
| oe_disable | input | 1 | Forces odd_even low |
| oe_auto | input | 1 | Enables the automatic forcing of odd_even low |
| picture_on | input | 1 | A TV picture is currently displayed |
| csync_n | output | 1 | Composite text sync, active low |
| disp_active | output | 1 | Display window strobe |
| odd_even | output | 1 | Field parity output for the deflection |
| field_id | output | 1 | Current field, 0 or 1 |
| line_no | output | LN_W (9) | Line within the field |
| tick_pos | output | TK_W (8) | Tick within the line |

## Verification
The hardest conditions to reach from the ports are the ones at field boundaries. These are the interlaced second field, which opens in mid-line with line number 0; the 626-half-line field of the 312/313 mode; and the return to a field start after a full frame. With the default timing, all of these lie tens of thousands of ticks away. The bench therefore runs a second instance with a 24-tick line through more than one complete frame in each mode, with random gaps in the tick. A default-timing instance runs alongside it on the same stimulus and pins down the real pulse and window edges. Both are compared on every cycle against a model that computes each position directly from the number of ticks elapsed since reset.

// File: rtl/tt_sync_pkg.sv
package tt_sync_pkg;

  typedef enum logic [1:0] {
    MODE_INTER  = 2'b00,
    MODE_NI_313 = 2'b01,
    MODE_NI_312 = 2'b10,
    MODE_SCAN   = 2'b11
  } tt_mode_e;

  typedef enum logic [1:0] {
    PULSE_NONE,
    PULSE_LINE,
    PULSE_EQ,
    PULSE_BROAD
  } pulse_e;

endpackage

// File: rtl/tt_line_timer.sv
module tt_line_timer #(
  parameter int TICKS_PER_LINE = 192,
  parameter int TK_W           = $clog2(TICKS_PER_LINE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  output logic [TK_W-1:0] tick_pos,
  output logic            half_end,
  output logic            line_end
);

  localparam logic [TK_W-1:0] LINE_LAST = TK_W'(TICKS_PER_LINE - 1);
  localparam logic [TK_W-1:0] HALF_LAST = TK_W'(TICKS_PER_LINE / 2 - 1);

  logic [TK_W-1:0] tick_q;
  logic [TK_W-1:0] tick_d;

  always_comb begin
    tick_d   = (tick_q == LINE_LAST) ? '0 : tick_q + TK_W'(1);
    line_end = tick_en && (tick_q == LINE_LAST);
    half_end = tick_en && ((tick_q == LINE_LAST) || (tick_q == HALF_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (tick_en) begin
      tick_q <= tick_d;
    end
  end

  assign tick_pos = tick_q;

endmodule

// File: rtl/tt_field_seq.sv
module tt_field_seq #(
  parameter int FIELD_HALVES = 625,
  parameter int HC_W         = $clog2(FIELD_HALVES + 2),
  parameter int LN_W         = $clog2(FIELD_HALVES / 2 + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_end,
  input  logic            line_end,
  input  logic            interlaced,
  input  logic            alt_long,
  output logic [HC_W-1:0] half_idx,
  output logic [LN_W-1:0] line_no,
  output logic            field_id
);

  localparam logic [HC_W-1:0] LAST_INTER = HC_W'(FIELD_HALVES - 1);
  localparam logic [HC_W-1:0] LAST_SHORT = HC_W'(FIELD_HALVES - 2);
  localparam logic [HC_W-1:0] LAST_LONG  = HC_W'(FIELD_HALVES);

  logic [HC_W-1:0] hc_q, hc_d, last_idx;
  logic [LN_W-1:0] ln_q, ln_d;
  logic            fld_q, fld_d;
  logic            wrap;

  always_comb begin
    if (interlaced)               last_idx = LAST_INTER;
    else if (alt_long && fld_q)   last_idx = LAST_LONG;
    else                          last_idx = LAST_SHORT;

    // non-interlaced fields may only close at a line end, which re-aligns
    // a field that was left starting mid-line by a mode change
    wrap = (hc_q >= last_idx) && (interlaced || line_end);

    if (wrap) begin
      hc_d  = '0;
      fld_d = ~fld_q;
      ln_d  = line_end ? LN_W'(1) : '0;
    end else begin
      hc_d  = hc_q + HC_W'(1);
      fld_d = fld_q;
      ln_d  = ln_q + LN_W'(line_end);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      ln_q  <= LN_W'(1);
      fld_q <= 1'b0;
    end else if (half_end) begin
      hc_q  <= hc_d;
      ln_q  <= ln_d;
      fld_q <= fld_d;
    end
  end

  assign half_idx = hc_q;
  assign line_no  = ln_q;
  assign field_id = fld_q;

endmodule

// File: rtl/tt_pulse_dec.sv
module tt_pulse_dec
  import tt_sync_pkg::*;
#(
  parameter int TICKS_PER_LINE = 192,
  parameter int SYNC_W         = 14,
  parameter int EQ_W           = 7,
  parameter int BROAD_W        = 82,
  parameter int WIN_START      = 50,
  parameter int WIN_END        = 170,
  parameter int FIRST_LINE     = 42,
  parameter int LAST_LINE      = 291,
  parameter int BLANK_HALVES   = 5,
  parameter int TK_W           = 8,
  parameter int HC_W           = 10,
  parameter int LN_W           = 9
) (
  input  logic [TK_W-1:0] tick_pos,
  input  logic [HC_W-1:0] half_idx,
  input  logic [LN_W-1:0] line_no,
  output logic            csync_n,
  output logic            disp_active
);

  localparam logic [TK_W-1:0] HALF_C  = TK_W'(TICKS_PER_LINE / 2);
  localparam logic [TK_W-1:0] SYNC_C  = TK_W'(SYNC_W);
  localparam logic [TK_W-1:0] EQ_C    = TK_W'(EQ_W);
  localparam logic [TK_W-1:0] BROAD_C = TK_W'(BROAD_W);
  localparam logic [TK_W-1:0] WS_C    = TK_W'(WIN_START);
  localparam logic [TK_W-1:0] WE_C    = TK_W'(WIN_END);
  localparam logic [HC_W-1:0] EQ1_END = HC_W'(BLANK_HALVES);
  localparam logic [HC_W-1:0] BR_END  = HC_W'(2 * BLANK_HALVES);
  localparam logic [HC_W-1:0] EQ2_END = HC_W'(3 * BLANK_HALVES);
  localparam logic [LN_W-1:0] FL_C    = LN_W'(FIRST_LINE);
  localparam logic [LN_W-1:0] LL_C    = LN_W'(LAST_LINE);

  logic            second_half;
  logic [TK_W-1:0] sub_tick;
  pulse_e          kind;
  logic            sync_low;

  always_comb begin
    second_half = (tick_pos >= HALF_C);
    sub_tick    = second_half ? (tick_pos - HALF_C) : tick_pos;

    if (half_idx < EQ1_END)      kind = PULSE_EQ;
    else if (half_idx < BR_END)  kind = PULSE_BROAD;
    else if (half_idx < EQ2_END) kind = PULSE_EQ;
    else if (!second_half)       kind = PULSE_LINE;
    else                         kind = PULSE_NONE;

    case (kind)
      PULSE_EQ:    sync_low = (sub_tick < EQ_C);
      PULSE_BROAD: sync_low = (sub_tick < BROAD_C);
      PULSE_LINE:  sync_low = (sub_tick < SYNC_C);
      default:     sync_low = 1'b0;
    endcase

    csync_n     = ~sync_low;
    disp_active = (half_idx >= EQ2_END) &&
                  (line_no >= FL_C) && (line_no <= LL_C) &&
                  (tick_pos >= WS_C) && (tick_pos < WE_C);
  end

endmodule

// File: rtl/tt_sync_gen.sv
module tt_sync_gen
  import tt_sync_pkg::*;
#(
  parameter int TICKS_PER_LINE = 192,
  parameter int SYNC_W         = 14,
  parameter int EQ_W           = 7,
  parameter int BROAD_W        = 82,
  parameter int WIN_START      = 50,
  parameter int WIN_END        = 170,
  parameter int FIRST_LINE     = 42,
  parameter int LAST_LINE      = 291,
  parameter int BLANK_HALVES   = 5,
  parameter int FIELD_HALVES   = 625,
  parameter int TK_W           = $clog2(TICKS_PER_LINE),
  parameter int LN_W           = $clog2(FIELD_HALVES / 2 + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic [1:0]      mode_sel,
  input  logic            flash_sub,
  input  logic            oe_disable,
  input  logic            oe_auto,
  input  logic            picture_on,
  output logic            csync_n,
  output logic            disp_active,
  output logic            odd_even,
  output logic            field_id,
  output logic [LN_W-1:0] line_no,
  output logic [TK_W-1:0] tick_pos
);

  localparam int HC_W = $clog2(FIELD_HALVES + 2);

  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  logic            half_end, line_end;
  logic            interlaced, alt_long;
  logic [HC_W-1:0] half_idx;
  tt_mode_e        mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    mode_e     = tt_mode_e'(mode_sel);
    interlaced = flash_sub || (mode_e == MODE_INTER) || (mode_e == MODE_SCAN);
    alt_long   = (mode_e == MODE_NI_313);
    odd_even   = field_id && !oe_disable && !(oe_auto && picture_on);
  end

  tt_line_timer #(
    .TICKS_PER_LINE(TICKS_PER_LINE),
    .TK_W          (TK_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_en (tick_en),
    .tick_pos(tick_pos),
    .half_end(half_end),
    .line_end(line_end)
  );

  tt_field_seq #(
    .FIELD_HALVES(FIELD_HALVES),
    .HC_W        (HC_W),
    .LN_W        (LN_W)
  ) u_field (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .half_end  (half_end),
    .line_end  (line_end),
    .interlaced(interlaced),
    .alt_long  (alt_long),
    .half_idx  (half_idx),
    .line_no   (line_no),
    .field_id  (field_id)
  );

  tt_pulse_dec #(
    .TICKS_PER_LINE(TICKS_PER_LINE),
    .SYNC_W        (SYNC_W),
    .EQ_W          (EQ_W),
    .BROAD_W       (BROAD_W),
    .WIN_START     (WIN_START),
    .WIN_END       (WIN_END),
    .FIRST_LINE    (FIRST_LINE),
    .LAST_LINE     (LAST_LINE),
    .BLANK_HALVES  (BLANK_HALVES),
    .TK_W          (TK_W),
    .HC_W          (HC_W),
    .LN_W          (LN_W)
  ) u_dec (
    .tick_pos   (tick_pos),
    .half_idx   (half_idx),
    .line_no    (line_no),
    .csync_n    (csync_n),
    .disp_active(disp_active)
  );

endmodule

// File: rtl/tt_sync_chk.sv
module tt_sync_chk #(
  parameter int TICKS_PER_LINE = 192,
  parameter int FIELD_HALVES   = 625,
  parameter int TK_W           = 8,
  parameter int LN_W           = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_en,
  input logic [TK_W-1:0] tick_pos,
  input logic            field_id,
  input logic [LN_W-1:0] line_no,
  input logic            csync_n,
  input logic            disp_active,
  input logic            odd_even,
  input logic            oe_disable
);

  localparam logic [TK_W-1:0] LAST_T  = TK_W'(TICKS_PER_LINE - 1);
  localparam logic [LN_W-1:0] MAX_LN  = LN_W'(FIELD_HALVES / 2 + 1);

  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tick_pos));

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && tick_pos == LAST_T) |=> tick_pos == '0);

  // R10
  field_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_id != $past(field_id)) |-> $past(tick_en));

  // R8
  field_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_id != $past(field_id)) |-> line_no <= LN_W'(1));

  // R8
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_no <= MAX_LN);

  // R9
  window_clear_of_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> csync_n);

  // R11
  oe_forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_disable |-> !odd_even);

endmodule

bind tt_sync_gen tt_sync_chk #(
  .TICKS_PER_LINE(TICKS_PER_LINE),
  .FIELD_HALVES  (FIELD_HALVES),
  .TK_W          (TK_W),
  .LN_W          (LN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .tick_pos   (tick_pos),
  .field_id   (field_id),
  .line_no    (line_no),
  .csync_n    (csync_n),
  .disp_active(disp_active),
  .odd_even   (odd_even),
  .oe_disable (oe_disable)
);

// File: tb/tt_sync_gen_tb.sv
module tt_sync_gen_tb;

  typedef struct {
    int tp;
    int ln;
    int fld;
    int cs;
    int de;
    int hc;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [1:0] mode_sel;
  logic       flash_sub, oe_disable, oe_auto, picture_on;

  logic       d_cs, d_de, d_oe, d_fld;
  logic [8:0] d_ln;
  logic [7:0] d_tp;
  logic       f_cs, f_de, f_oe, f_fld;
  logic [8:0] f_ln;
  logic [4:0] f_tp;

  int checks = 0;
  int fails  = 0;
  int n      = 0;

  always #4 clk = ~clk;

  tt_sync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .flash_sub(flash_sub), .oe_disable(oe_disable), .oe_auto(oe_auto),
    .picture_on(picture_on), .csync_n(d_cs), .disp_active(d_de),
    .odd_even(d_oe), .field_id(d_fld), .line_no(d_ln), .tick_pos(d_tp)
  );

  tt_sync_gen #(
    .TICKS_PER_LINE(24), .SYNC_W(2), .EQ_W(1), .BROAD_W(10),
    .WIN_START(6), .WIN_END(21)
  ) u_fast (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .flash_sub(flash_sub), .oe_disable(oe_disable), .oe_auto(oe_auto),
    .picture_on(picture_on), .csync_n(f_cs), .disp_active(f_de),
    .odd_even(f_oe), .field_id(f_fld), .line_no(f_ln), .tick_pos(f_tp)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails <= 30)
        $display("FAIL %s %s actual=%0d expected=%0d tick=%0d", tag, what, act, exp, n);
    end
  endtask

  // Expected outputs from the tick count since reset; md: 0 interlaced, 1 312/313, 2 312/312
  function automatic exp_t model(int nt, int tpl, int syw, int eqw, int brw,
                                 int ws, int we, int md);
    exp_t e;
    int half, hl, th, per, len0, r, odd_start;
    half = tpl / 2;
    hl   = nt / half;
    th   = nt % half;
    if (md == 0)      begin per = 1250; len0 = 625; end
    else if (md == 1) begin per = 1250; len0 = 624; end
    else              begin per = 1248; len0 = 624; end
    r     = hl % per;
    e.fld = (r >= len0) ? 1 : 0;
    e.hc  = e.fld ? r - len0 : r;
    odd_start = (e.fld == 1) && (len0 % 2 == 1);
    e.ln  = odd_start ? (e.hc + 1) / 2 : e.hc / 2 + 1;
    e.tp  = nt % tpl;
    if (e.hc < 5 || (e.hc >= 10 && e.hc < 15)) e.cs = (th < eqw) ? 0 : 1;
    else if (e.hc < 10)                         e.cs = (th < brw) ? 0 : 1;
    else if (hl % 2 == 0)                       e.cs = (th < syw) ? 0 : 1;
    else                                        e.cs = 1;
    e.de = (e.hc >= 15 && e.ln >= 42 && e.ln <= 291 && e.tp >= ws && e.tp < we) ? 1 : 0;
    return e;
  endfunction

  task automatic cmp(string nm, exp_t e, int tp, int ln, int fld, int cs,
                     int de, int oe, string ftag);
    string stag, otag;
    int    oexp;
    if (e.hc < 5 || (e.hc >= 10 && e.hc < 15)) stag = "R4";
    else if (e.hc < 10)                         stag = "R5";
    else                                        stag = "R3";
    if (oe_disable)                 otag = "R11";
    else if (oe_auto && picture_on) otag = "R12";
    else                            otag = "R10";
    oexp = (e.fld == 1 && !oe_disable && !(oe_auto && picture_on)) ? 1 : 0;
    chk("R2",  {nm, " tick_pos"},    tp,  e.tp);
    chk(stag,  {nm, " csync_n"},     cs,  e.cs);
    chk("R8",  {nm, " line_no"},     ln,  e.ln);
    chk(ftag,  {nm, " field_id"},    fld, e.fld);
    chk("R9",  {nm, " disp_active"}, de,  e.de);
    chk(otag,  {nm, " odd_even"},    oe,  oexp);
  endtask

  task automatic run_mode(logic [1:0] m, logic fs, int md, int nticks, string ftag);
    exp_t ed, ef;
    @(negedge clk);
    tick_en = 1'b0; mode_sel = m; flash_sub = fs;
    oe_disable = 1'b0; oe_auto = 1'b0; picture_on = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n = 0;
    // R1 reset state
    chk("R1", "tick_pos", int'(d_tp), 0);
    chk("R1", "line_no",  int'(d_ln), 1);
    chk("R1", "field_id", int'(d_fld), 0);
    chk("R1", "odd_even", int'(d_oe), 0);
    chk("R1", "disp_active", int'(d_de), 0);
    chk("R1", "csync_n", int'(d_cs), 0);
    while (n < nticks) begin
      tick_en    = (($urandom % 8) != 0);
      oe_disable = (($urandom % 4) == 0);
      oe_auto    = $urandom % 2;
      picture_on = $urandom % 2;
      @(negedge clk);
      if (tick_en) n++;
      ed = model(n, 192, 14, 7, 82, 50, 170, md);
      ef = model(n, 24, 2, 1, 10, 6, 21, md);
      cmp("dflt", ed, int'(d_tp), int'(d_ln), int'(d_fld), int'(d_cs),
          int'(d_de), int'(d_oe), ftag);
      cmp("fast", ef, int'(f_tp), int'(f_ln), int'(f_fld), int'(f_cs),
          int'(f_de), int'(f_oe), ftag);
    end
  endtask

  initial begin
    void'($urandom(32'h1F3A_5C07));
    rst_n = 1'b0; tick_en = 1'b0; mode_sel = 2'b00; flash_sub = 1'b0;
    oe_disable = 1'b0; oe_auto = 1'b0; picture_on = 1'b0;
    run_mode(2'b00, 1'b0, 0, 15600, "R6");   // interlaced, mid-line second field
    run_mode(2'b01, 1'b0, 1, 15600, "R6");   // 312/313 alternate
    run_mode(2'b10, 1'b0, 2, 15600, "R6");   // 312/312
    run_mode(2'b11, 1'b0, 0, 15600, "R6");   // scan-locked handled as interlaced
    run_mode(2'b10, 1'b1, 0, 15600, "R7");   // override forces interlaced
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", n, 15600);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule